// File: doc/BRIEF.md
# Operand Addressing Mode Decoder

This block turns a 6-bit operand specifier into everything a processor's operand stage needs: the addressing mode, which register to read as the base, the access width, and how many extension words the operand takes from the instruction stream. In the same pass it forms the effective address and any update to the base register. The register file and memory stay outside. The register number to read is presented combinationally on `base_sel_o`, and the register file returns its value on `rd_val_i` in the same cycle.

The specifier covers several modes. The first is a direct register, R0 to R15. Then come an immediate word, an absolute address, register indirect, indirect with post-increment, and indexed. In the memory modes the base register comes from R8 to R15. Indirect access through the stack register R15 works as a stack: a read pops and a write pushes. Post-increment steps by the access width. One specifier is an illegal register/width combination. The block flags it and holds back the register update for it. Results are registered by default (`OUT_REG=1`), so they appear one clock after the inputs. A combinational variant is also available.

Top module: `opnd_decoder`

## Requirements
- R1: Specifiers 0x00–0x0F give mode 0 (register). The register number is bits 3:0, with no extension word, no write-back and word width. The mode codes are: 0 register, 1 immediate, 2 direct, 3 indirect, 4 post-increment, 5 indexed.
- R2: Specifier 0x1F gives mode 1 (immediate). It uses one extension word, and that word appears on `ea_o`. Width is word and there is no write-back.
- R3: Specifiers 0x27 and 0x2F give mode 2 (direct). The address is the extension word, one extension word is consumed, and bit 3 selects byte (1) or word (0).
- R4: In the other memory modes, bit 3 selects byte (1) or word (0). The base register on `base_sel_o` is bits 2:0 plus 8. Bits 5:4 pick the mode: 01 indirect, 10 post-increment, 11 indexed.
- R5: Indirect through R8–R14 uses the register value as the address, with no write-back and no extension word.
- R6: Post-increment uses the register value as the address. It writes back that value plus 1 for byte width or plus 2 for word width.
- R7: Indexed uses the register value plus the extension word, modulo 2^16. It consumes one extension word and has no write-back, and this includes R15 with word width (0x37).
- R8: Indirect read through R15 (0x17, `is_write_i`=0) uses R15 as the address and writes back R15+2.
- R9: Indirect write through R15 (0x17, `is_write_i`=1) uses R15−2 as the address and writes back R15−2, with wrap at zero.
- R10: Specifier 0x3F (indexed, byte, R15) raises `illegal_o`. It produces no write-back and reports zero extension words.
- R11: With `OUT_REG=1`, all outputs except `base_sel_o` follow the inputs by one clock. Reset clears mode, address, write-back, width, extension count and the illegal flag to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spec_i | input | 6 | Operand specifier |
| rd_val_i | input | 16 | Value of the register named by `base_sel_o` |
| ext_i | input | 16 | Extension word from the instruction stream |
| is_write_i | input | 1 | 1 when the operand is a destination |
| base_sel_o | output | 4 | Register to read (combinational) |
| mode_o | output | 3 | Addressing mode code |
| ea_o | output | 16 | Effective address, or immediate value |
| wb_en_o | output | 1 | Base register write-back enable |
| wb_reg_o | output | 4 | Register to write back |
| wb_val_o | output | 16 | Write-back value |
| byte_o | output | 1 | 1 for byte access |
| ext_cnt_o | output | 2 | Extension words consumed |
| illegal_o | output | 1 | Forbidden encoding |

## Verification
Address generation and base write-back happen in the same cycle. They are driven by the same register value but use different offsets.

The bench exercises them together with stack pop, stack push and post-increment. For a pop and for post-increment, the address must be the old value and the write-back must be the new one. For a push, both must equal the decremented value, including the wrap from 0x0000 to 0xFFFE.

The illegal specifier is applied with a non-zero register value. This shows that no write-back leaks through when the flag is set.

// File: rtl/opnd_pkg.sv
package opnd_pkg;
   localparam int SPEC_W = 6;
   localparam int REG_W  = 4;
   typedef enum logic [2:0] {
      AM_REG  = 3'd0,
      AM_IMM  = 3'd1,
      AM_DIR  = 3'd2,
      AM_IND  = 3'd3,
      AM_POST = 3'd4,
      AM_IDX  = 3'd5
   } amode_t;
endpackage

// File: rtl/opnd_spec_decode.sv
module opnd_spec_decode
   import opnd_pkg::*;
#(
   parameter int STACK_REG = 15
) (
   input  logic [SPEC_W-1:0] spec,
   output amode_t            mode,
   output logic [REG_W-1:0]  base,
   output logic              byte_acc,
   output logic [1:0]        ext_cnt,
   output logic              illegal
);
   localparam logic [REG_W-1:0] SP_IDX = REG_W'(STACK_REG);

   always_comb begin
      mode     = AM_REG;
      base     = spec[REG_W-1:0];
      byte_acc = 1'b0;
      ext_cnt  = 2'd0;
      illegal  = 1'b0;
      if (spec[5:4] == 2'b00) begin
         mode = AM_REG;
      end else if (spec == 6'h1F) begin
         mode    = AM_IMM;
         base    = '0;
         ext_cnt = 2'd1;
      end else if ((spec & 6'h37) == 6'h27) begin
         mode     = AM_DIR;
         base     = '0;
         byte_acc = spec[3];
         ext_cnt  = 2'd1;
      end else begin
         base     = REG_W'(8) + REG_W'(spec[2:0]);
         byte_acc = spec[3];
         case (spec[5:4])
            2'b01:   mode = AM_IND;
            2'b10:   mode = AM_POST;
            default: begin
               mode    = AM_IDX;
               ext_cnt = 2'd1;
            end
         endcase
         if (base == SP_IDX && (byte_acc || mode == AM_POST)) begin
            illegal = 1'b1;
            ext_cnt = 2'd0;
         end
      end
   end
endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen
   import opnd_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int STACK_REG = 15
) (
   input  amode_t             mode,
   input  logic [REG_W-1:0]   base,
   input  logic               byte_acc,
   input  logic               illegal,
   input  logic [DATA_W-1:0]  rd_val,
   input  logic [DATA_W-1:0]  ext,
   input  logic               is_write,
   output logic [DATA_W-1:0]  ea,
   output logic               wb_en,
   output logic [DATA_W-1:0]  wb_val
);
   localparam logic [DATA_W-1:0] WORD_STEP = DATA_W'(DATA_W / 8);
   localparam logic [DATA_W-1:0] BYTE_STEP = DATA_W'(1);
   localparam logic [REG_W-1:0]  SP_IDX    = REG_W'(STACK_REG);

   logic on_stack;
   assign on_stack = (base == SP_IDX);

   always_comb begin
      ea     = '0;
      wb_en  = 1'b0;
      wb_val = rd_val;
      case (mode)
         AM_IMM, AM_DIR: ea = ext;
         AM_IND: begin
            if (on_stack && is_write) begin
               ea     = rd_val - WORD_STEP;
               wb_en  = 1'b1;
               wb_val = rd_val - WORD_STEP;
            end else if (on_stack) begin
               ea     = rd_val;
               wb_en  = 1'b1;
               wb_val = rd_val + WORD_STEP;
            end else begin
               ea = rd_val;
            end
         end
         AM_POST: begin
            ea     = rd_val;
            wb_en  = 1'b1;
            wb_val = rd_val + (byte_acc ? BYTE_STEP : WORD_STEP);
         end
         AM_IDX:  ea = rd_val + ext;
         default: ea = '0;
      endcase
      if (illegal) wb_en = 1'b0;
   end
endmodule

// File: rtl/opnd_decoder.sv
module opnd_decoder
   import opnd_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int STACK_REG = 15,
   parameter bit OUT_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [5:0]        spec_i,
   input  logic [DATA_W-1:0] rd_val_i,
   input  logic [DATA_W-1:0] ext_i,
   input  logic              is_write_i,
   output logic [3:0]        base_sel_o,
   output logic [2:0]        mode_o,
   output logic [DATA_W-1:0] ea_o,
   output logic              wb_en_o,
   output logic [3:0]        wb_reg_o,
   output logic [DATA_W-1:0] wb_val_o,
   output logic              byte_o,
   output logic [1:0]        ext_cnt_o,
   output logic              illegal_o
);
   if (DATA_W < 16 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("opnd_decoder: DATA_W must be a multiple of 8 and at least 16");
   end
   if (STACK_REG < 8 || STACK_REG > 15) begin : g_bad_stack
      $error("opnd_decoder: STACK_REG must name one of R8..R15");
   end

   amode_t             d_mode;
   logic [REG_W-1:0]   d_base;
   logic               d_byte;
   logic [1:0]         d_ext;
   logic               d_ill;
   logic [DATA_W-1:0]  a_ea;
   logic               a_wb_en;
   logic [DATA_W-1:0]  a_wb_val;

   opnd_spec_decode #(.STACK_REG(STACK_REG)) u_dec (
      .spec     (spec_i),
      .mode     (d_mode),
      .base     (d_base),
      .byte_acc (d_byte),
      .ext_cnt  (d_ext),
      .illegal  (d_ill)
   );

   opnd_addr_gen #(.DATA_W(DATA_W), .STACK_REG(STACK_REG)) u_agen (
      .mode     (d_mode),
      .base     (d_base),
      .byte_acc (d_byte),
      .illegal  (d_ill),
      .rd_val   (rd_val_i),
      .ext      (ext_i),
      .is_write (is_write_i),
      .ea       (a_ea),
      .wb_en    (a_wb_en),
      .wb_val   (a_wb_val)
   );

   assign base_sel_o = d_base;

   if (OUT_REG) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mode_o    <= 3'd0;
            ea_o      <= '0;
            wb_en_o   <= 1'b0;
            wb_reg_o  <= '0;
            wb_val_o  <= '0;
            byte_o    <= 1'b0;
            ext_cnt_o <= 2'd0;
            illegal_o <= 1'b0;
         end else begin
            mode_o    <= d_mode;
            ea_o      <= a_ea;
            wb_en_o   <= a_wb_en;
            wb_reg_o  <= d_base;
            wb_val_o  <= a_wb_val;
            byte_o    <= d_byte;
            ext_cnt_o <= d_ext;
            illegal_o <= d_ill;
         end
      end
   end else begin : g_comb_out
      always_comb begin
         mode_o    = d_mode;
         ea_o      = a_ea;
         wb_en_o   = a_wb_en;
         wb_reg_o  = d_base;
         wb_val_o  = a_wb_val;
         byte_o    = d_byte;
         ext_cnt_o = d_ext;
         illegal_o = d_ill;
      end
   end
endmodule

// File: rtl/opnd_decoder_chk.sv
module opnd_decoder_chk
   import opnd_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int STACK_REG = 15,
   parameter bit OUT_REG   = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [5:0]        spec_i,
   input logic [DATA_W-1:0] ext_i,
   input logic [2:0]        mode_o,
   input logic [DATA_W-1:0] ea_o,
   input logic              wb_en_o,
   input logic [3:0]        wb_reg_o,
   input logic [DATA_W-1:0] wb_val_o,
   input logic              byte_o,
   input logic [1:0]        ext_cnt_o,
   input logic              illegal_o
);
   localparam logic [DATA_W-1:0] WSTEP = DATA_W'(DATA_W / 8);

   // R10
   illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> (!wb_en_o && ext_cnt_o == 2'd0));

   // R1
   reg_mode_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd0) |-> (!wb_en_o && ext_cnt_o == 2'd0 && !byte_o));

   // R8
   stack_only_ind_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en_o && mode_o == 3'd3) |->
         (wb_reg_o == 4'(STACK_REG) && (wb_val_o == ea_o + WSTEP || wb_val_o == ea_o)));

   // R6
   post_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd4 && !illegal_o) |->
         (wb_en_o && (wb_val_o - ea_o) == (byte_o ? DATA_W'(1) : WSTEP)));

   // R7
   ext_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_o == 3'd1 || mode_o == 3'd2 || mode_o == 3'd5) && !illegal_o) |->
         (ext_cnt_o == 2'd1));

   if (OUT_REG) begin : g_lat
      // R11
      imm_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (spec_i == 6'h1F) |=> (mode_o == 3'd1 && ea_o == $past(ext_i)));
   end
endmodule

bind opnd_decoder opnd_decoder_chk #(
   .DATA_W(DATA_W), .STACK_REG(STACK_REG), .OUT_REG(OUT_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .spec_i(spec_i), .ext_i(ext_i),
   .mode_o(mode_o), .ea_o(ea_o), .wb_en_o(wb_en_o), .wb_reg_o(wb_reg_o),
   .wb_val_o(wb_val_o), .byte_o(byte_o), .ext_cnt_o(ext_cnt_o),
   .illegal_o(illegal_o)
);

// File: tb/opnd_decoder_test.sv
`timescale 1ns/1ps
module opnd_decoder_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  spec_i = '0;
   logic [15:0] rd_val_i = '0;
   logic [15:0] ext_i = '0;
   logic        is_write_i = 1'b0;
   logic [3:0]  base_sel_o;
   logic [2:0]  mode_o;
   logic [15:0] ea_o;
   logic        wb_en_o;
   logic [3:0]  wb_reg_o;
   logic [15:0] wb_val_o;
   logic        byte_o;
   logic [1:0]  ext_cnt_o;
   logic        illegal_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   opnd_decoder uut (
      .clk(clk), .rst_n(rst_n), .spec_i(spec_i), .rd_val_i(rd_val_i),
      .ext_i(ext_i), .is_write_i(is_write_i), .base_sel_o(base_sel_o),
      .mode_o(mode_o), .ea_o(ea_o), .wb_en_o(wb_en_o), .wb_reg_o(wb_reg_o),
      .wb_val_o(wb_val_o), .byte_o(byte_o), .ext_cnt_o(ext_cnt_o),
      .illegal_o(illegal_o)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   // drive at a falling edge, check the combinational select, then check the
   // registered outputs at the following falling edge (one rising edge later)
   task automatic run(input string tag, input logic [5:0] sp, input logic [15:0] rv,
                      input logic [15:0] ex, input logic wr,
                      input logic [3:0] e_sel, input logic [2:0] e_mode,
                      input logic [15:0] e_ea, input logic e_wb,
                      input logic [15:0] e_wbv, input logic e_byte,
                      input logic [1:0] e_ext, input logic e_ill);
      @(negedge clk);
      spec_i = sp; rd_val_i = rv; ext_i = ex; is_write_i = wr;
      #1;
      chk({tag, " base_sel"}, 32'(base_sel_o), 32'(e_sel));
      @(negedge clk);
      chk({tag, " mode"}, 32'(mode_o), 32'(e_mode));
      chk({tag, " ea"}, 32'(ea_o), 32'(e_ea));
      chk({tag, " wb_en"}, 32'(wb_en_o), 32'(e_wb));
      if (e_wb) begin
         chk({tag, " wb_reg"}, 32'(wb_reg_o), 32'(e_sel));
         chk({tag, " wb_val"}, 32'(wb_val_o), 32'(e_wbv));
      end
      chk({tag, " byte"}, 32'(byte_o), 32'(e_byte));
      chk({tag, " ext_cnt"}, 32'(ext_cnt_o), 32'(e_ext));
      chk({tag, " illegal"}, 32'(illegal_o), 32'(e_ill));
   endtask

   task automatic t_reset();
      chk("R11 reset mode", 32'(mode_o), 0);
      chk("R11 reset ea", 32'(ea_o), 0);
      chk("R11 reset wb_en", 32'(wb_en_o), 0);
      chk("R11 reset ext_cnt", 32'(ext_cnt_o), 0);
      chk("R11 reset illegal", 32'(illegal_o), 0);
   endtask

   task automatic t_register();
      run("R1 reg R5", 6'h05, 16'h1234, 16'hAAAA, 1'b0, 4'd5, 3'd0, 16'h0, 1'b0, 16'h0, 1'b0, 2'd0, 1'b0);
      run("R1 reg R15", 6'h0F, 16'h4000, 16'h0000, 1'b1, 4'd15, 3'd0, 16'h0, 1'b0, 16'h0, 1'b0, 2'd0, 1'b0);
   endtask

   task automatic t_imm_direct();
      run("R2 imm", 6'h1F, 16'h0000, 16'hBEEF, 1'b0, 4'd0, 3'd1, 16'hBEEF, 1'b0, 16'h0, 1'b0, 2'd1, 1'b0);
      run("R3 direct word", 6'h27, 16'h5555, 16'h3000, 1'b1, 4'd0, 3'd2, 16'h3000, 1'b0, 16'h0, 1'b0, 2'd1, 1'b0);
      run("R3 direct byte", 6'h2F, 16'h5555, 16'h3001, 1'b0, 4'd0, 3'd2, 16'h3001, 1'b0, 16'h0, 1'b1, 2'd1, 1'b0);
   endtask

   task automatic t_indirect();
      run("R4 R5 ind word R10", 6'h12, 16'h0800, 16'h1111, 1'b0, 4'd10, 3'd3, 16'h0800, 1'b0, 16'h0, 1'b0, 2'd0, 1'b0);
      run("R4 R5 ind byte R9 write", 6'h19, 16'h0ABC, 16'h0, 1'b1, 4'd9, 3'd3, 16'h0ABC, 1'b0, 16'h0, 1'b1, 2'd0, 1'b0);
   endtask

   task automatic t_postinc();
      run("R6 post word R12", 6'h24, 16'h2000, 16'h0, 1'b0, 4'd12, 3'd4, 16'h2000, 1'b1, 16'h2002, 1'b0, 2'd0, 1'b0);
      run("R6 post byte R12", 6'h2C, 16'h2000, 16'h0, 1'b1, 4'd12, 3'd4, 16'h2000, 1'b1, 16'h2001, 1'b1, 2'd0, 1'b0);
      run("R6 post word wrap R8", 6'h20, 16'hFFFF, 16'h0, 1'b0, 4'd8, 3'd4, 16'hFFFF, 1'b1, 16'h0001, 1'b0, 2'd0, 1'b0);
   endtask

   task automatic t_indexed();
      run("R7 idx R11 wrap", 6'h33, 16'hFFF0, 16'h0020, 1'b0, 4'd11, 3'd5, 16'h0010, 1'b0, 16'h0, 1'b0, 2'd1, 1'b0);
      run("R7 idx byte R14", 6'h3E, 16'h1000, 16'h0005, 1'b1, 4'd14, 3'd5, 16'h1005, 1'b0, 16'h0, 1'b1, 2'd1, 1'b0);
      run("R7 idx R15 word", 6'h37, 16'h03F0, 16'h0004, 1'b0, 4'd15, 3'd5, 16'h03F4, 1'b0, 16'h0, 1'b0, 2'd1, 1'b0);
   endtask

   task automatic t_stack();
      run("R8 pop", 6'h17, 16'h03F0, 16'h0, 1'b0, 4'd15, 3'd3, 16'h03F0, 1'b1, 16'h03F2, 1'b0, 2'd0, 1'b0);
      run("R9 push", 6'h17, 16'h0400, 16'h0, 1'b1, 4'd15, 3'd3, 16'h03FE, 1'b1, 16'h03FE, 1'b0, 2'd0, 1'b0);
      run("R9 push wrap", 6'h17, 16'h0000, 16'h0, 1'b1, 4'd15, 3'd3, 16'hFFFE, 1'b1, 16'hFFFE, 1'b0, 2'd0, 1'b0);
   endtask

   task automatic t_illegal();
      run("R10 idx byte R15 read", 6'h3F, 16'h0400, 16'h0002, 1'b0, 4'd15, 3'd5, 16'h0402, 1'b0, 16'h0, 1'b1, 2'd0, 1'b1);
      run("R10 idx byte R15 write", 6'h3F, 16'h0400, 16'h0002, 1'b1, 4'd15, 3'd5, 16'h0402, 1'b0, 16'h0, 1'b1, 2'd0, 1'b1);
      // back-to-back legal operand clears the flag (R10, R11)
      run("R10 recover", 6'h17, 16'h0100, 16'h0, 1'b0, 4'd15, 3'd3, 16'h0100, 1'b1, 16'h0102, 1'b0, 2'd0, 1'b0);
   endtask

   initial begin
      #100000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_register();
      t_imm_direct();
      t_indirect();
      t_postinc();
      t_indexed();
      t_stack();
      t_illegal();
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule